// File: doc/BRIEF.md
# Cascadable Serial Command Slave

This block is the serial front end of a device that holds a small internal register file. A host selects the device by pulling an active-low select line low, then clocks in a fixed 24-bit command frame, most significant bit first. SDI is sampled on each falling serial-clock edge. When the select line is released, the block checks that a whole frame arrived. It then splits the frame into a direction flag, a register address and a 16-bit data word, and gives the register file a one-cycle write strobe or a one-cycle read request.

The serial pins are oversampled by the block's system clock through a synchronizer. All of the frame logic therefore runs in one clock domain. The serial output can be cascaded to the input of another device of the same kind. In normal mode it replays the bits that leave the 24-bit shift register, so a chain of N devices is loaded with 24×N clocks. Two bits of a configuration register held inside the block can switch the output driver off or put the block to sleep. While asleep, the serial input is wired straight to the serial output and commands are refused. A separate wake pin is the only way out of sleep.

Top module: `spi_chain_slave`

## Requirements
- R1: A frame holds the read/write flag at bit 23, the address at bits 22..18, the data at bits 17..2 and two reserved bits at 1..0. A flag of 0 with at least 24 falling edges produces exactly one `reg_wr_stb` pulse, carrying the frame's address on `reg_addr` and its data on `reg_wdata`.
- R2: A flag of 1 produces exactly one `reg_rd_req` pulse with the frame's address, and no write strobe.
- R3: If the select line rises after fewer than 24 falling serial-clock edges, no strobe and no request is issued.
- R4: If more than 24 falling edges occur, the last 24 bits shifted in form the command.
- R5: A command takes effect only after the select line rises. Holding the select line low after the 24th edge issues nothing.
- R6: While the select line is high, serial-clock and data activity has no effect and `spi_sdo_oe` is 0.
- R7: In normal mode, `spi_sdo` presents each input bit 24 serial clocks after it entered, launched on the rising edge. Two cascaded devices given 48 clocks each receive their own frame: the first 24 bits sent go to the far device.
- R8: A write to configuration address 1 with data bit 1 set turns the output driver off (`spi_sdo_oe` stays 0 with the select line low). Writing the bit back to 0 turns the driver on again.
- R9: A write to configuration address 1 with data bit 0 set puts the block to sleep: `sleep_o` is 1, `spi_sdo` follows `spi_sdi` combinationally, and later frames issue no strobe.
- R10: A high level on `wake_i` clears sleep, and commands are accepted again afterwards.
- R11: After reset, no strobe is pending, `sleep_o` is 0 and the output driver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock; idles high, SDI sampled on the falling edge |
| spi_cs_n | input | 1 | Active-low select; its rising edge commits the frame |
| spi_sdi | input | 1 | Serial data in |
| wake_i | input | 1 | Asynchronous wake request that clears sleep |
| spi_sdo | output | 1 | Serial data out (delayed chain data or bypass) |
| spi_sdo_oe | output | 1 | Output-driver enable for the pad |
| reg_wr_stb | output | 1 | One-cycle write strobe toward the register file |
| reg_rd_req | output | 1 | One-cycle read request toward the register file |
| reg_addr | output | ADDR_W | Register address of the last command |
| reg_wdata | output | DATA_W | Data word of the last write |
| sleep_o | output | 1 | Block is in bypass sleep |

## Verification
The bench tests the frame-length boundary from both sides. A 23-edge frame must be dropped: a design that commits partial frames would write a shifted, half-filled word. Frames of 25 to 32 edges must decode from their tail: a counter that wraps instead of saturating would reject them. Two devices are cascaded with 48 clocks, and the serial output is sampled just before each falling edge. This exposes a chain delay that is off by one bit (both devices would decode a rotated frame) and a launch on the wrong clock edge. Sleep is entered and left through the wake pin. A block that kept shifting while asleep would issue commands that the bypass should have passed through.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

   // lane positions inside the synchronizer vector
   localparam int unsigned LANE_SCLK = 0;
   localparam int unsigned LANE_CSN  = 1;
   localparam int unsigned LANE_SDI  = 2;
   localparam int unsigned LANE_WAKE = 3;
   localparam int unsigned N_LANES   = 4;

   // idle values: clock high, select high, data and wake low
   localparam logic [N_LANES-1:0] LANE_IDLE = 4'b0011;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2
   } cmd_kind_e;

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
   import spi_chain_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic cs_n_pin,
   input  logic sdi_pin,
   input  logic wake_pin,
   output logic sclk_fall,
   output logic sclk_rise,
   output logic cs_low,
   output logic cs_fall,
   output logic cs_rise,
   output logic sdi_s,
   output logic wake_s
);

   logic [STAGES-1:0][N_LANES-1:0] stage_q;
   logic [N_LANES-1:0]             raw;
   logic [N_LANES-1:0]             cur;
   logic [N_LANES-1:0]             prev_q;

   always_comb begin
      raw            = '0;
      raw[LANE_SCLK] = sclk_pin;
      raw[LANE_CSN]  = cs_n_pin;
      raw[LANE_SDI]  = sdi_pin;
      raw[LANE_WAKE] = wake_pin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= {STAGES{LANE_IDLE}};
         prev_q  <= LANE_IDLE;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], raw};
         prev_q  <= stage_q[STAGES-1];
      end
   end

   assign cur       = stage_q[STAGES-1];
   assign sclk_fall = prev_q[LANE_SCLK] & ~cur[LANE_SCLK];
   assign sclk_rise = ~prev_q[LANE_SCLK] & cur[LANE_SCLK];
   assign cs_low    = ~cur[LANE_CSN];
   assign cs_fall   = prev_q[LANE_CSN] & ~cur[LANE_CSN];
   assign cs_rise   = ~prev_q[LANE_CSN] & cur[LANE_CSN];
   assign sdi_s     = cur[LANE_SDI];
   assign wake_s    = cur[LANE_WAKE];

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
   parameter int unsigned FRAME_W = 24,
   localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_low,
   input  logic               cs_fall,
   input  logic               cs_rise,
   input  logic               sclk_fall,
   input  logic               sdi_s,
   input  logic               shift_en,
   output logic [FRAME_W-1:0] frame_o,
   output logic               commit_o,
   output logic               msb_o
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         cnt_q    <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (cs_fall) begin
            shreg_q <= '0;
            cnt_q   <= '0;
         end else if (cs_low && sclk_fall && shift_en) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s};
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
         end
         if (cs_rise && shift_en && (cnt_q == FULL)) commit_q <= 1'b1;
      end
   end

   assign frame_o  = shreg_q;
   assign commit_o = commit_q;
   assign msb_o    = shreg_q[FRAME_W-1];

   // counter saturates so overlong frames still qualify
   assert_cnt_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // no shifting while the device is deselected
   assert_hold_deselected_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_low |=> $stable(shreg_q));

   // a commit only follows release of the select line
   assert_commit_after_release_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> !cs_low);

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_chain_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CFG_ADDR  = 1,
   parameter int unsigned SLEEP_BIT = 0,
   parameter int unsigned DSDO_BIT  = 1,
   localparam int unsigned CMD_W    = 1 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic              commit_i,
   input  logic              wake_s,
   output logic              wr_stb_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              sleep_o,
   output logic              sdo_dis_o
);

   localparam int unsigned RW_POS = CMD_W - 1;

   logic              rw_bit;
   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] f_data;
   cmd_kind_e         kind;
   logic              cfg_hit;

   logic              wr_q, rd_q, sleep_q, dis_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   assign rw_bit  = cmd_i[RW_POS];
   assign f_addr  = cmd_i[RW_POS-1 -: ADDR_W];
   assign f_data  = cmd_i[DATA_W-1:0];
   assign cfg_hit = (f_addr == ADDR_W'(CFG_ADDR));

   always_comb begin
      kind = CMD_NONE;
      if (commit_i) kind = rw_bit ? CMD_READ : CMD_WRITE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         sleep_q <= 1'b0;
         dis_q   <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         unique case (kind)
            CMD_WRITE: begin
               wr_q    <= 1'b1;
               addr_q  <= f_addr;
               wdata_q <= f_data;
               if (cfg_hit) begin
                  sleep_q <= f_data[SLEEP_BIT];
                  dis_q   <= f_data[DSDO_BIT];
               end
            end
            CMD_READ: begin
               rd_q   <= 1'b1;
               addr_q <= f_addr;
            end
            default: ;
         endcase
         if (wake_s) sleep_q <= 1'b0;
      end
   end

   assign wr_stb_o  = wr_q;
   assign rd_req_o  = rd_q;
   assign addr_o    = addr_q;
   assign wdata_o   = wdata_q;
   assign sleep_o   = sleep_q;
   assign sdo_dis_o = dis_q;

   // write and read never issue together
   assert_strobe_excl_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_q && rd_q));

   // strobes are single-cycle pulses
   assert_single_pulse_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);

   // nothing issues once sleep has held for a cycle
   assert_quiet_asleep_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_q && $past(sleep_q)) |-> (!wr_q && !rd_q));

   // wake always wins over sleep
   assert_wake_clears_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_s |=> !sleep_q);

endmodule

// File: rtl/spi_sdo_drive.sv
module spi_sdo_drive #(
   parameter bit SLEEP_BYPASS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_low,
   input  logic cs_fall,
   input  logic sclk_rise,
   input  logic msb_i,
   input  logic sleep_i,
   input  logic sdo_dis_i,
   input  logic cs_n_pin,
   input  logic sdi_pin,
   output logic sdo_o,
   output logic sdo_oe_o
);

   logic sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   sdo_q <= 1'b0;
      else if (cs_fall)             sdo_q <= 1'b0;
      else if (sclk_rise && cs_low) sdo_q <= msb_i;
   end

   if (SLEEP_BYPASS) begin : g_bypass
      assign sdo_o = sleep_i ? sdi_pin : sdo_q;
   end else begin : g_no_bypass
      logic unused_sleep;
      assign unused_sleep = sleep_i;
      assign sdo_o = sdo_q;
   end

   assign sdo_oe_o = ~cs_n_pin & ~sdo_dis_i;

   // chain data only moves on a rising serial edge (or frame start)
   assert_launch_on_rise_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_rise && !cs_fall) |=> $stable(sdo_q));

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave #(
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned RSV_W        = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned CFG_ADDR     = 1,
   parameter int unsigned SLEEP_BIT    = 0,
   parameter int unsigned DSDO_BIT     = 1,
   parameter bit          SLEEP_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   input  logic              wake_i,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   output logic              reg_wr_stb,
   output logic              reg_rd_req,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              sleep_o
);

   localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W + RSV_W;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SLEEP_BIT >= DATA_W || DSDO_BIT >= DATA_W) begin : g_chk_bits
      $error("configuration bits must lie inside the data word");
   end
   if (SLEEP_BIT == DSDO_BIT) begin : g_chk_overlap
      $error("sleep and output-disable bits must differ");
   end
   if (CFG_ADDR >= (1 << ADDR_W)) begin : g_chk_cfg
      $error("CFG_ADDR does not fit in ADDR_W");
   end
   if (FRAME_W < 2) begin : g_chk_frame
      $error("frame too short");
   end

   logic sclk_fall, sclk_rise, cs_low, cs_fall, cs_rise, sdi_s, wake_s;
   logic [FRAME_W-1:0] frame;
   logic commit, msb, sleep, sdo_dis;
   logic [RSV_W-1:0] unused_rsv;

   spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_pin  (spi_sclk),
      .cs_n_pin  (spi_cs_n),
      .sdi_pin   (spi_sdi),
      .wake_pin  (wake_i),
      .sclk_fall (sclk_fall),
      .sclk_rise (sclk_rise),
      .cs_low    (cs_low),
      .cs_fall   (cs_fall),
      .cs_rise   (cs_rise),
      .sdi_s     (sdi_s),
      .wake_s    (wake_s)
   );

   spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_low    (cs_low),
      .cs_fall   (cs_fall),
      .cs_rise   (cs_rise),
      .sclk_fall (sclk_fall),
      .sdi_s     (sdi_s),
      .shift_en  (~sleep),
      .frame_o   (frame),
      .commit_o  (commit),
      .msb_o     (msb)
   );

   assign unused_rsv = frame[RSV_W-1:0];

   spi_cmd_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CFG_ADDR  (CFG_ADDR),
      .SLEEP_BIT (SLEEP_BIT),
      .DSDO_BIT  (DSDO_BIT)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (frame[FRAME_W-1:RSV_W]),
      .commit_i  (commit),
      .wake_s    (wake_s),
      .wr_stb_o  (reg_wr_stb),
      .rd_req_o  (reg_rd_req),
      .addr_o    (reg_addr),
      .wdata_o   (reg_wdata),
      .sleep_o   (sleep),
      .sdo_dis_o (sdo_dis)
   );

   spi_sdo_drive #(.SLEEP_BYPASS(SLEEP_BYPASS)) u_sdo (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_low    (cs_low),
      .cs_fall   (cs_fall),
      .sclk_rise (sclk_rise),
      .msb_i     (msb),
      .sleep_i   (sleep),
      .sdo_dis_i (sdo_dis),
      .cs_n_pin  (spi_cs_n),
      .sdi_pin   (spi_sdi),
      .sdo_o     (spi_sdo),
      .sdo_oe_o  (spi_sdo_oe)
   );

   assign sleep_o = sleep;

endmodule

// File: tb/spi_chain_slave_tb.sv
module spi_chain_slave_tb;

   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, wake = 1'b0;

   logic sdo_a, oe_a, wr_a, rd_a, sleep_a;
   logic [4:0] addr_a;
   logic [15:0] wdata_a;
   logic sdo_b, oe_b, wr_b, rd_b, sleep_b;
   logic [4:0] addr_b;
   logic [15:0] wdata_b;

   int checks = 0, fails = 0;
   int wr_cnt_a = 0, rd_cnt_a = 0, wr_cnt_b = 0;
   logic [4:0] last_addr_a, last_addr_b;
   logic [15:0] last_data_a, last_data_b;
   logic cap [0:71];
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_chain_slave u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
      .wake_i(wake), .spi_sdo(sdo_a), .spi_sdo_oe(oe_a), .reg_wr_stb(wr_a),
      .reg_rd_req(rd_a), .reg_addr(addr_a), .reg_wdata(wdata_a), .sleep_o(sleep_a)
   );

   spi_chain_slave #(.CFG_ADDR(31)) u_dut2 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdo_a),
      .wake_i(wake), .spi_sdo(sdo_b), .spi_sdo_oe(oe_b), .reg_wr_stb(wr_b),
      .reg_rd_req(rd_b), .reg_addr(addr_b), .reg_wdata(wdata_b), .sleep_o(sleep_b)
   );

   always @(posedge clk) begin
      if (wr_a) begin wr_cnt_a <= wr_cnt_a + 1; last_addr_a <= addr_a; last_data_a <= wdata_a; end
      if (rd_a) begin rd_cnt_a <= rd_cnt_a + 1; last_addr_a <= addr_a; end
      if (wr_b) begin wr_cnt_b <= wr_cnt_b + 1; last_addr_b <= addr_b; last_data_b <= wdata_b; end
   end

   function automatic logic [23:0] mkf(input logic rw, input logic [4:0] a,
                                       input logic [15:0] d, input logic [1:0] r);
      return {rw, a, d, r};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // send n bits of v, v[n-1] first; capture sdo just before each fall
   task automatic send(input logic [71:0] v, input int n, input bit release_cs);
      cs_n = 1'b0;
      waitc(H);
      for (int i = 0; i < n; i++) begin
         sdi = v[n-1-i];
         waitc(H);
         cap[i] = sdo_a;
         sclk = 1'b0;
         waitc(H);
         sclk = 1'b1;
      end
      waitc(H);
      if (release_cs) begin
         cs_n = 1'b1;
         waitc(12);
      end
   endtask

   task automatic expect_frame(input string req, input logic [23:0] f, input int n,
                               input logic [71:0] v);
      int w0, r0;
      w0 = wr_cnt_a; r0 = rd_cnt_a;
      send(v, n, 1'b1);
      if (n < 24) begin
         check(req, "wr count short", wr_cnt_a - w0, 0);
         check(req, "rd count short", rd_cnt_a - r0, 0);
      end else if (f[23]) begin
         check(req, "rd count", rd_cnt_a - r0, 1);
         check(req, "wr count", wr_cnt_a - w0, 0);
         check(req, "rd addr", 32'(last_addr_a), 32'(f[22:18]));
      end else begin
         check(req, "wr count", wr_cnt_a - w0, 1);
         check(req, "rd count", rd_cnt_a - r0, 0);
         check(req, "wr addr", 32'(last_addr_a), 32'(f[22:18]));
         check(req, "wr data", 32'(last_data_a), 32'(f[17:2]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [23:0] f;
      logic [71:0] v;
      int w0;
      void'($urandom(32'd24681));
      waitc(5);
      rst_n = 1'b1;
      waitc(5);

      // R11: reset state
      check("R11", "oe", 32'(oe_a), 0);
      check("R11", "sleep", 32'(sleep_a), 0);
      check("R11", "strobes", 32'(wr_a | rd_a), 0);

      // R1: plain write
      f = mkf(1'b0, 5'h05, 16'hA5C3, 2'b10);
      expect_frame("R1", f, 24, 72'(f));
      // R2: read
      f = mkf(1'b1, 5'h12, 16'h1234, 2'b00);
      expect_frame("R2", f, 24, 72'(f));
      // R3: one short of a frame, and a single bit
      f = mkf(1'b0, 5'h07, 16'hFFFF, 2'b11);
      expect_frame("R3", f, 23, 72'(f[23:1]));
      expect_frame("R3", f, 1, 72'(1));

      // R4 + R7: 48-bit stream, tail forms the command, head emerges after 24 clocks
      f = mkf(1'b0, 5'h0A, 16'h5A0F, 2'b01);
      v = {24'h000000, 24'hC3A596, f};
      expect_frame("R4", f, 48, v);
      for (int k = 24; k < 48; k++)
         check("R7", "sdo delayed bit", 32'(cap[k]), 32'(v[47-(k-24)]));

      // R5: hold select low after a full frame
      f = mkf(1'b0, 5'h03, 16'h0F0F, 2'b00);
      w0 = wr_cnt_a;
      send(72'(f), 24, 1'b0);
      waitc(40);
      check("R5", "wr before release", wr_cnt_a - w0, 0);
      cs_n = 1'b1;
      waitc(12);
      check("R5", "wr after release", wr_cnt_a - w0, 1);

      // R6: clocking with select high
      w0 = wr_cnt_a;
      for (int i = 0; i < 30; i++) begin
         sdi = 1'($urandom);
         sclk = 1'b0; waitc(H);
         sclk = 1'b1; waitc(H);
         check("R6", "oe while deselected", 32'(oe_a), 0);
      end
      waitc(12);
      check("R6", "no strobe deselected", wr_cnt_a - w0, 0);
      check("R6", "no read deselected", 32'(rd_a), 0);

      // R7: two-device chain, far device gets the first frame
      begin
         logic [23:0] fa, fb;
         int wb;
         fb = mkf(1'b0, 5'h0C, 16'hBEEF, 2'b00);
         fa = mkf(1'b0, 5'h06, 16'h1357, 2'b00);
         w0 = wr_cnt_a; wb = wr_cnt_b;
         send({24'h0, fb, fa}, 48, 1'b1);
         check("R7", "near wr", wr_cnt_a - w0, 1);
         check("R7", "near data", 32'(last_data_a), 32'h1357);
         check("R7", "far wr", wr_cnt_b - wb, 1);
         check("R7", "far addr", 32'(last_addr_b), 32'h0C);
         check("R7", "far data", 32'(last_data_b), 32'hBEEF);
      end

      // R8: output disable
      f = mkf(1'b0, 5'h01, 16'h0002, 2'b00);
      send(72'(f), 24, 1'b1);
      cs_n = 1'b0; waitc(10);
      check("R8", "oe disabled", 32'(oe_a), 0);
      cs_n = 1'b1; waitc(10);
      f = mkf(1'b0, 5'h01, 16'h0000, 2'b00);
      send(72'(f), 24, 1'b1);
      cs_n = 1'b0; waitc(10);
      check("R8", "oe re-enabled", 32'(oe_a), 1);
      cs_n = 1'b1; waitc(10);

      // R9: sleep bypass
      f = mkf(1'b0, 5'h01, 16'h0001, 2'b00);
      send(72'(f), 24, 1'b1);
      check("R9", "sleep set", 32'(sleep_a), 1);
      cs_n = 1'b0; waitc(4);
      for (int i = 0; i < 6; i++) begin
         sdi = 1'(i % 2);
         #1;
         check("R9", "bypass sdo", 32'(sdo_a), 32'(i % 2));
         waitc(2);
      end
      cs_n = 1'b1; waitc(10);
      w0 = wr_cnt_a;
      f = mkf(1'b0, 5'h05, 16'h7777, 2'b00);
      send(72'(f), 24, 1'b1);
      check("R9", "frame ignored asleep", wr_cnt_a - w0, 0);

      // R10: wake
      wake = 1'b1; waitc(8); wake = 1'b0; waitc(8);
      check("R10", "sleep cleared", 32'(sleep_a), 0);
      f = mkf(1'b0, 5'h09, 16'h2468, 2'b00);
      expect_frame("R10", f, 24, 72'(f));

      // random frames: exact, overlong and short
      for (int t = 0; t < 24; t++) begin
         logic [4:0] a;
         int n;
         a = 5'($urandom % 28) + 5'd2;
         f = mkf(1'($urandom), a, 16'($urandom), 2'($urandom));
         if (t % 6 == 5) n = 10 + int'($urandom % 14);
         else n = 24 + int'($urandom % 9);
         v = 72'(f);
         if (n < 24) v = 72'(f) >> (24 - n);
         else for (int b = 24; b < n; b++) v[b] = 1'($urandom);
         expect_frame(n < 24 ? "R3" : (n > 24 ? "R4" : "R1"), f, n, v);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule